// File: doc/BRIEF.md
# Programmable Chip-Select Bus Controller

This block sits between a host request interface and an asynchronous peripheral port that is 16 bits wide. When a host request falls inside the configured bank, the block drives a 3-bit word address, a write/read direction line, write data and an active-low select toward the peripheral. It then ends the cycle and returns a one-cycle completion pulse to the host, with read data for reads.

The controller runs on a fast clock at four times the bus rate, so one fast cycle is one quarter of a bus clock. Timing comes from option fields on the configuration inputs. A 2-bit setup code sets how many quarter clocks pass between the address becoming valid and select asserting. A wait-state count sets the minimum select width in whole bus clocks. A termination bit chooses between ending the cycle internally and waiting for the peripheral's acknowledge. The acknowledge input is asynchronous and passes through a two-stage synchronizer. Bank decode compares the masked host address with the masked base address and is gated by a valid bit.

Top module: `csel_bus_ctrl`

## Requirements
- R1: The peripheral word address equals host byte-address bits 3..1. Host bit 0 has no effect on it.
- R2: On a write, the direction line is low and the write data and word address are already driven in the fast cycle where select first goes low. All three stay unchanged until select returns high.
- R3: On a read, the direction line is high while select is low. The host read data, valid while done is high, equals the peripheral data present on the last fast cycle of select.
- R4: The number of fast cycles from address valid to select low is 0 for setup code 00, 4 for 01, 1 for 10 and 2 for 11.
- R5: With termination bit 0, select stays low for exactly 4*(1+wait) fast cycles, and the acknowledge line has no effect.
- R6: With termination bit 1, select stays low for at least 4*(1+wait) fast cycles. The cycle ends on the first synchronized low acknowledge after that. If acknowledge goes low in the d-th select cycle (d counted from 0), the select width is max(4*(1+wait), d+3).
- R7: A request starts a cycle only when the valid bit is 1 and ((host_addr XOR base) AND mask) is zero. Otherwise select stays high and no done pulse is issued.
- R8: Done is high for exactly one fast cycle, namely the first cycle in which select is high again.
- R9: After reset, select is high, the direction line is high and done is low.
- R10: A request that arrives while a cycle is in progress is dropped and does not start another cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, sampled when the controller is idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| cfg_base | input | ADDR_W | Bank base address |
| cfg_mask | input | ADDR_W | Address compare mask (1 = compared) |
| cfg_valid | input | 1 | Bank enable |
| cfg_setup | input | 2 | Address-to-select setup code |
| cfg_wait | input | WS_W | Wait states in bus clocks |
| cfg_ext_term | input | 1 | 1 = end on acknowledge, 0 = end internally |
| per_addr | output | 3 | Peripheral word address |
| per_sel_n | output | 1 | Active-low select |
| per_wr_n | output | 1 | Direction, low = write, high = read |
| per_dout | output | DATA_W | Data toward the peripheral |
| per_din | input | DATA_W | Data from the peripheral |
| per_ack_n | input | 1 | Asynchronous active-low acknowledge |

## Verification
The hardest case to produce is an acknowledge that arrives early, either before the minimum width in external mode or at any time in internal mode. Because of the synchronizer latency, it is also hard to know in which cycle it takes effect. The bench pulls acknowledge low in a chosen select cycle, counted at falling edges. It sweeps that cycle across both sides of the minimum width and expects a width of max(4*(1+wait), d+3). Every setup code is crossed with several wait counts and both directions, and each access checks the setup delay and the select width. A second request is injected mid-cycle to show that the busy controller drops it.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2
  } csel_state_e;

  // Quarter-clock delay between address valid and select assertion.
  function automatic logic [2:0] setup_quarters(input logic [1:0] code);
    case (code)
      2'b00:   setup_quarters = 3'd0;
      2'b01:   setup_quarters = 3'd4;
      2'b10:   setup_quarters = 3'd1;
      default: setup_quarters = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              valid,
  output logic              hit
);
  always_comb begin
    hit = valid && (((addr ^ base) & mask) == '0);
  end
endmodule

// File: rtl/csel_sync.sv
module csel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csel_seq.sv
module csel_seq
  import csel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we,
  input  logic [2:0]        word_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        setup_code,
  input  logic [WS_W-1:0]   wait_states,
  input  logic              ext_term,
  input  logic              ack_n_s,
  input  logic [DATA_W-1:0] per_din,
  output logic [2:0]        per_addr,
  output logic              per_sel_n,
  output logic              per_wr_n,
  output logic [DATA_W-1:0] per_dout,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = WS_W + 2;

  csel_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] setup_m1;
  logic [2:0]       quarters;

  always_comb begin
    quarters = setup_quarters(setup_code);
    len_m1   = {wait_states, 2'b11};
    setup_m1 = CNT_W'(quarters) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      per_addr  <= '0;
      per_sel_n <= 1'b1;
      per_wr_n  <= 1'b1;
      per_dout  <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            per_addr <= word_addr;
            per_wr_n <= ~we;
            per_dout <= wdata;
            if (quarters == 3'd0) begin
              per_sel_n <= 1'b0;
              cnt       <= len_m1;
              state     <= ST_ACTIVE;
            end else begin
              cnt   <= setup_m1;
              state <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            per_sel_n <= 1'b0;
            cnt       <= len_m1;
            state     <= ST_ACTIVE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (cnt == '0) begin
            if (!ext_term || !ack_n_s) begin
              per_sel_n <= 1'b1;
              done      <= 1'b1;
              if (per_wr_n) rdata <= per_din;
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csel_bus_ctrl.sv
module csel_bus_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int WS_W     = 4,
  parameter int ACK_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_setup,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              cfg_ext_term,
  output logic [2:0]        per_addr,
  output logic              per_sel_n,
  output logic              per_wr_n,
  output logic [DATA_W-1:0] per_dout,
  input  logic [DATA_W-1:0] per_din,
  input  logic              per_ack_n
);
  logic bank_hit;
  logic ack_n_s;
  logic start;

  csel_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (host_addr),
    .base  (cfg_base),
    .mask  (cfg_mask),
    .valid (cfg_valid),
    .hit   (bank_hit)
  );

  csel_sync #(.STAGES(ACK_SYNC)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (per_ack_n),
    .q   (ack_n_s)
  );

  assign start = host_req & bank_hit;

  csel_seq #(.DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .we          (host_we),
    .word_addr   (host_addr[3:1]),
    .wdata       (host_wdata),
    .setup_code  (cfg_setup),
    .wait_states (cfg_wait),
    .ext_term    (cfg_ext_term),
    .ack_n_s     (ack_n_s),
    .per_din     (per_din),
    .per_addr    (per_addr),
    .per_sel_n   (per_sel_n),
    .per_wr_n    (per_wr_n),
    .per_dout    (per_dout),
    .done        (host_done),
    .rdata       (host_rdata)
  );
endmodule

// File: rtl/csel_bus_ctrl_chk.sv
module csel_bus_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int WS_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              per_sel_n,
  input logic [2:0]        per_addr,
  input logic              per_wr_n,
  input logic [DATA_W-1:0] per_dout,
  input logic              host_done,
  input logic [WS_W-1:0]   cfg_wait,
  input logic              cfg_ext_term
);
  localparam int LW = WS_W + 4;

  logic [LW-1:0] low_cnt;
  logic [LW-1:0] min_len;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (!per_sel_n) low_cnt <= low_cnt + LW'(1);
    else                 low_cnt <= '0;
  end

  always_comb min_len = (LW'(cfg_wait) << 2) + LW'(4);

  AST_HOLD_DURING_SEL: assert property (@(posedge clk) disable iff (rst)
    (!per_sel_n && $past(!per_sel_n)) |->
      ($stable(per_addr) && $stable(per_wr_n) && $stable(per_dout))) else $error("hold"); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done) else $error("done pulse"); // R8

  AST_DONE_ON_SEL_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(per_sel_n) |-> host_done) else $error("done missing"); // R8

  AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    host_done |-> $rose(per_sel_n)) else $error("stray done"); // R8

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(per_sel_n) |-> (low_cnt >= min_len)) else $error("short select"); // R6

  AST_INTERNAL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($rose(per_sel_n) && !cfg_ext_term) |-> (low_cnt == min_len)) else $error("width"); // R5
endmodule

bind csel_bus_ctrl csel_bus_ctrl_chk #(.DATA_W(DATA_W), .WS_W(WS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .per_sel_n    (per_sel_n),
  .per_addr     (per_addr),
  .per_wr_n     (per_wr_n),
  .per_dout     (per_dout),
  .host_done    (host_done),
  .cfg_wait     (cfg_wait),
  .cfg_ext_term (cfg_ext_term)
);

// File: tb/test_csel_bus_ctrl.sv
module test_csel_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [31:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_done;
  logic [31:0] cfg_base = 32'h4001_0000;
  logic [31:0] cfg_mask = 32'hFFFF_0000;
  logic        cfg_valid = 1'b1;
  logic [1:0]  cfg_setup = 2'b00;
  logic [3:0]  cfg_wait = 4'd0;
  logic        cfg_ext_term = 1'b0;
  logic [2:0]  per_addr;
  logic        per_sel_n;
  logic        per_wr_n;
  logic [15:0] per_dout;
  logic [15:0] per_din = '0;
  logic        per_ack_n = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csel_bus_ctrl i_csel_bus_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int quarters(input logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 4;
      2'b10: return 1;
      default: return 2;
    endcase
  endfunction

  // d < 0: acknowledge never driven low
  task automatic access(input bit we, input logic [31:0] a, input logic [15:0] wd,
                        input logic [1:0] su, input logic [3:0] ws, input bit ext,
                        input int d, input bit poke);
    int sc = 0, lc = 0, guard = 0, len, explen, stray = 0;
    bit hold_ok = 1, done_early = 0;
    cfg_setup = su; cfg_wait = ws; cfg_ext_term = ext;
    per_din = 16'hA000 ^ a[15:0];
    len = 4 * (1 + int'(ws));
    explen = (ext && (d + 3 > len)) ? d + 3 : len;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    chk(per_addr == a[3:1], "R1 word address", int'(per_addr), int'(a[3:1]));
    chk(per_wr_n == !we, we ? "R2 direction" : "R3 direction", int'(per_wr_n), int'(!we));
    while (per_sel_n && guard < 100) begin
      sc++; guard++; @(negedge clk);
    end
    chk(sc == quarters(su), "R4 setup delay", sc, quarters(su));
    while (!per_sel_n && guard < 300) begin
      lc++; guard++;
      if (per_addr != a[3:1] || per_wr_n != !we || (we && per_dout != wd)) hold_ok = 0;
      if (host_done) done_early = 1;
      if (d >= 0 && lc == d + 1) per_ack_n = 1'b0;
      if (poke && lc == 1) begin
        host_req = 1'b1; host_addr = a ^ 32'h6;
      end else host_req = 1'b0;
      @(negedge clk);
    end
    host_req = 1'b0;
    chk(lc == explen, ext ? "R6 select width" : "R5 select width", lc, explen);
    chk(hold_ok, "R2 hold while selected", int'(hold_ok), 1);
    chk(host_done && !done_early, "R8 done at end", int'(host_done), 1);
    if (!we) chk(host_rdata == per_din, "R3 read data", int'(host_rdata), int'(per_din));
    per_ack_n = 1'b1;
    @(negedge clk);
    chk(!host_done, "R8 done one cycle", int'(host_done), 0);
    repeat (12) begin
      if (!per_sel_n) stray++;
      @(negedge clk);
    end
    if (poke) chk(stray == 0, "R10 request while busy", stray, 0);
  endtask

  task automatic miss(input logic [31:0] a, input bit v, input string tag);
    int seen = 0;
    cfg_valid = v;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = 16'h1234;
    @(negedge clk);
    host_req = 1'b0;
    repeat (30) begin
      if (!per_sel_n || host_done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, tag, seen, 0);
    cfg_valid = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(per_sel_n == 1'b1, "R9 reset select", int'(per_sel_n), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(per_sel_n == 1'b1 && per_wr_n == 1'b1, "R9 reset select/dir",
        int'({per_sel_n, per_wr_n}), 3);
    chk(host_done == 1'b0, "R9 reset done", int'(host_done), 0);

    // R4/R5/R2/R3 sweep; in internal mode ack is pulled low at once (must be ignored)
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 3; w++) begin
        for (int rw = 0; rw < 2; rw++) begin
          int idx = s * 6 + w * 2 + rw;
          logic [31:0] a = 32'h4001_0000 | 32'(((idx % 8) << 1) | (idx & 1));
          logic [3:0]  ws = (w == 2) ? 4'd3 : 4'(w);
          access(rw == 1, a, 16'(16'h5A00 + idx * 37), 2'(s), ws, 1'b0, 0, 1'b0);
        end
      end
    end

    // R6: external termination, ack before, at and after the minimum
    access(1'b0, 32'h4001_0006, 16'h0, 2'b10, 4'd1, 1'b1, 0, 1'b0);
    access(1'b1, 32'h4001_000A, 16'hBEEF, 2'b00, 4'd1, 1'b1, 5, 1'b0);
    access(1'b0, 32'h4001_000C, 16'h0, 2'b11, 4'd1, 1'b1, 10, 1'b0);
    access(1'b1, 32'h4001_000E, 16'hC0DE, 2'b01, 4'd0, 1'b1, 20, 1'b0);

    // R10: second request injected mid-cycle
    access(1'b1, 32'h4001_0004, 16'h7777, 2'b10, 4'd2, 1'b0, -1, 1'b1);

    // R7: decode misses
    miss(32'h4002_0004, 1'b1, "R7 address outside bank");
    miss(32'h4001_0004, 1'b0, "R7 bank not valid");
    access(1'b0, 32'h4001_FFF3, 16'h0, 2'b00, 4'd0, 1'b0, -1, 1'b0); // R7 top of bank hits

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule